// File: doc/BRIEF.md
# Frame-Aligned Initialization Sequencer

This block runs chip initialization for a time-division-multiplexed switch. An active-low initialization request is looked at once per 125 µs frame only: in the clock cycle where the frame-sync pulse is high and the timeslot counter reads zero (the frame strobe). A low request at the strobe starts an initialization pass that lasts exactly one frame, however short or long the request pulse was. During the pass the block walks every connection-memory address in ascending order and issues a clear write to each one. It also holds two disable flags: one for the processor-bus output drivers and one for the PCM output drivers.

If the request is still low at the next strobe, the pass starts again from address zero for one more frame. If the request is high at that strobe, the pass ends. The processor-bus drivers are then released at once. The PCM drivers stay disabled until the surrounding logic signals that a connection has been programmed. With the default parameters (256 entries, two clocks per entry, 512 clocks per frame at 4.096 MHz), the sweep uses the whole frame. The connection memory itself lies outside the block. An ordinary active-low register reset brings the block to a defined idle state at power-up.

Top module: `frm_init_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `bus_drv_dis` is 0, `pcm_drv_dis` is 1 and `mem_clr_we` is 0.
- R2: `init_n` is sampled only on a frame strobe: a rising clock edge with `frame_sync` = 1 and `ts` = 0. A low `init_n` at any other edge, including `frame_sync` = 1 with a non-zero `ts`, leaves `bus_drv_dis` and `mem_clr_we` unchanged.
- R3: A frame strobe with `init_n` = 0 sets `bus_drv_dis` and `pcm_drv_dis` to 1 from the next cycle on. They stay set until the next frame strobe, even if `init_n` returned high after a single cycle.
- R4: After a starting strobe, `mem_clr_we` is 1 in the cycles at offsets 0, CPE, 2·CPE, … (offset 0 is the cycle just after the strobe), with `mem_clr_addr` = offset/CPE. This gives DEPTH writes to addresses 0 to DEPTH-1 in ascending order. `mem_clr_we` stays 0 after the last write, even if the next strobe comes late.
- R5: A frame strobe with `init_n` = 0 while a pass is running restarts the sweep at address 0 in the next cycle and keeps both disable flags at 1.
- R6: A frame strobe with `init_n` = 1 clears `bus_drv_dis` in the next cycle and stops clear writes.
- R7: `pcm_drv_dis` is 1 whenever `bus_drv_dis` is 1, and it stays 1 after a pass. It drops to 0 in the cycle after a `conn_set` = 1 edge taken while `bus_drv_dis` is 0. A `conn_set` during a pass is ignored.
- R8: `mem_clr_we` is 1 only while `bus_drv_dis` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low register reset |
| frame_sync | input | 1 | Frame-start pulse, one cycle wide |
| ts | input | TS_W | Current timeslot number |
| init_n | input | 1 | Active-low initialization request, sampled on the frame strobe |
| conn_set | input | 1 | Pulse: a connection has been programmed |
| mem_clr_addr | output | $clog2(DEPTH) | Connection-memory address being cleared |
| mem_clr_we | output | 1 | Clear-write enable for the connection memory |
| bus_drv_dis | output | 1 | Disable for the processor-bus output drivers |
| pcm_drv_dis | output | 1 | Disable for the PCM output drivers |

## Verification
The assertions assume that `init_n`, `frame_sync` and `ts` are already synchronous to `clk`. They also assume that `frame_sync` is a single-cycle pulse whose strobe meaning depends on `ts` reading zero. They put no bound on the spacing between strobes. The stimulus changes every input one time unit after a rising edge. It raises `frame_sync` only for single cycles, sometimes with a non-zero `ts`, so that non-strobe pulses are exercised. It spaces strobes both exactly one frame apart and later than that, so that the sweep-completion behaviour is seen.

// File: rtl/frm_init_pkg.sv
package frm_init_pkg;

   // Events decoded from one frame strobe
   typedef struct packed {
      logic start;   // strobe seen with request low
      logic stop;    // strobe seen with request high
   } frm_evt_t;

   localparam int unsigned DEF_TS_W       = 5;
   localparam int unsigned DEF_DEPTH      = 256;
   localparam int unsigned DEF_CPE        = 2;
   localparam int unsigned DEF_FRAME_CLKS = 512;

endpackage

// File: rtl/frm_init_strobe.sv
module frm_init_strobe
   import frm_init_pkg::*;
#(
   parameter int unsigned TS_W = DEF_TS_W
) (
   input  logic            frame_sync,
   input  logic [TS_W-1:0] ts,
   input  logic            init_n,
   output frm_evt_t        evt
);

   logic strobe;

   assign strobe    = frame_sync & (ts == '0);
   assign evt.start = strobe & ~init_n;
   assign evt.stop  = strobe &  init_n;

endmodule

// File: rtl/frm_init_sweep.sv
module frm_init_sweep #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned CPE   = 2,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          active,
   output logic [AW-1:0] addr,
   output logic          we
);

   logic          done_q;
   logic [AW-1:0] addr_q;
   logic          ph_zero;
   logic          ph_last;
   logic          run;

   assign run = active & ~done_q;

   generate
      if (CPE == 1) begin : g_ph_none
         assign ph_zero = 1'b1;
         assign ph_last = 1'b1;
      end else begin : g_ph_cnt
         localparam int unsigned PW = $clog2(CPE);
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ph_q <= '0;
            else if (restart) ph_q <= '0;
            else if (run)     ph_q <= ph_last ? '0 : ph_q + 1'b1;
         end
         assign ph_zero = (ph_q == '0);
         assign ph_last = (ph_q == PW'(CPE - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         done_q <= 1'b1;
      end else if (restart) begin
         addr_q <= '0;
         done_q <= 1'b0;
      end else if (run && ph_last) begin
         if (addr_q == AW'(DEPTH - 1)) done_q <= 1'b1;
         else                          addr_q <= addr_q + 1'b1;
      end
   end

   assign addr = addr_q;
   assign we   = run & ph_zero;

endmodule

// File: rtl/frm_init_drv.sv
module frm_init_drv
   import frm_init_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  frm_evt_t evt,
   input  logic     conn_set,
   output logic     init_act,
   output logic     pcm_dis
);

   logic act_q;
   logic pcm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         pcm_q <= 1'b1;
      end else begin
         if (evt.start)     act_q <= 1'b1;
         else if (evt.stop) act_q <= 1'b0;

         if (evt.start)                 pcm_q <= 1'b1;
         else if (conn_set && !act_q)   pcm_q <= 1'b0;
      end
   end

   assign init_act = act_q;
   assign pcm_dis  = pcm_q;

endmodule

// File: rtl/frm_init_seq.sv
module frm_init_seq
   import frm_init_pkg::*;
#(
   parameter int unsigned TS_W       = DEF_TS_W,
   parameter int unsigned DEPTH      = DEF_DEPTH,
   parameter int unsigned CPE        = DEF_CPE,
   parameter int unsigned FRAME_CLKS = DEF_FRAME_CLKS,
   localparam int unsigned AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_sync,
   input  logic [TS_W-1:0] ts,
   input  logic            init_n,
   input  logic            conn_set,
   output logic [AW-1:0]   mem_clr_addr,
   output logic            mem_clr_we,
   output logic            bus_drv_dis,
   output logic            pcm_drv_dis
);

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (CPE >= 1) else $error("CPE must be at least 1");
      assert (DEPTH * CPE <= FRAME_CLKS)
         else $error("sweep does not fit in one frame");
   end

   frm_evt_t evt;
   logic     init_act;

   frm_init_strobe #(.TS_W(TS_W)) u_strobe (
      .frame_sync (frame_sync),
      .ts         (ts),
      .init_n     (init_n),
      .evt        (evt)
   );

   frm_init_drv u_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .conn_set (conn_set),
      .init_act (init_act),
      .pcm_dis  (pcm_drv_dis)
   );

   frm_init_sweep #(.DEPTH(DEPTH), .CPE(CPE)) u_sweep (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (evt.start),
      .active  (init_act),
      .addr    (mem_clr_addr),
      .we      (mem_clr_we)
   );

   assign bus_drv_dis = init_act;

endmodule

// File: rtl/frm_init_seq_chk.sv
module frm_init_seq_chk #(
   parameter int unsigned TS_W = 5,
   parameter int unsigned AW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            frame_sync,
   input logic [TS_W-1:0] ts,
   input logic            init_n,
   input logic            conn_set,
   input logic [AW-1:0]   mem_clr_addr,
   input logic            mem_clr_we,
   input logic            bus_drv_dis,
   input logic            pcm_drv_dis
);

   AST_WE_ONLY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_clr_we |-> bus_drv_dis);                                         // R8
   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sync && ts == '0 && !init_n) |=>
         (bus_drv_dis && pcm_drv_dis && mem_clr_we && mem_clr_addr == '0)); // R3
   AST_NO_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_sync && ts == '0) |=> $stable(bus_drv_dis));                  // R2
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sync && ts == '0 && init_n) |=> (!bus_drv_dis && !mem_clr_we)); // R6
   AST_PCM_COVERS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drv_dis |-> pcm_drv_dis);                                        // R7
   AST_CONN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drv_dis && !(frame_sync && ts == '0)) |=> pcm_drv_dis);          // R7

endmodule

bind frm_init_seq frm_init_seq_chk #(.TS_W(TS_W), .AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_sync   (frame_sync),
   .ts           (ts),
   .init_n       (init_n),
   .conn_set     (conn_set),
   .mem_clr_addr (mem_clr_addr),
   .mem_clr_we   (mem_clr_we),
   .bus_drv_dis  (bus_drv_dis),
   .pcm_drv_dis  (pcm_drv_dis)
);

// File: tb/frm_init_seq_tb.sv
module frm_init_seq_tb;

   localparam int TS_W  = 5;
   localparam int DEPTH = 256;
   localparam int CPE   = 2;
   localparam int FRAME = 512;
   localparam int AW    = 8;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            frame_sync;
   logic [TS_W-1:0] ts;
   logic            init_n;
   logic            conn_set;
   logic [AW-1:0]   mem_clr_addr;
   logic            mem_clr_we;
   logic            bus_drv_dis;
   logic            pcm_drv_dis;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   frm_init_seq #(.TS_W(TS_W), .DEPTH(DEPTH), .CPE(CPE), .FRAME_CLKS(FRAME)) u_dut (
      .clk (clk), .rst_n (rst_n), .frame_sync (frame_sync), .ts (ts),
      .init_n (init_n), .conn_set (conn_set), .mem_clr_addr (mem_clr_addr),
      .mem_clr_we (mem_clr_we), .bus_drv_dis (bus_drv_dis), .pcm_drv_dis (pcm_drv_dis)
   );

   // {frame_sync, ts[4:0], init_n, expected bus_drv_dis}
   localparam logic [7:0] VEC [6] = '{
      8'b0_00000_0_0,   // no sync, request low
      8'b1_00101_0_0,   // sync with timeslot 5
      8'b1_11111_0_0,   // sync with timeslot 31
      8'b0_00111_0_0,   // no sync, timeslot 7
      8'b1_00000_1_0,   // strobe, request high
      8'b1_00000_0_1    // strobe, request low
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic s, input logic [TS_W-1:0] t, input logic in_n, input logic c);
      frame_sync = s; ts = t; init_n = in_n; conn_set = c;
      @(posedge clk);
      #1;
   endtask

   // Observes offsets 0..len-1 of a pass, then issues the next strobe
   task automatic frame_pass(input logic idle_in, input int len, input int conn_at,
                             input logic next_in);
      int errs = 0;
      int writes = 0;
      for (int i = 0; i < len; i++) begin
         bit exp_we = (i % CPE == 0) && (i < CPE * DEPTH);
         if (mem_clr_we !== exp_we) errs++;
         if (exp_we && mem_clr_addr !== AW'(i / CPE)) errs++;
         if (mem_clr_we === 1'b1) writes++;
         if (bus_drv_dis !== 1'b1 || pcm_drv_dis !== 1'b1) errs++;
         if (i < len - 1) step(1'b0, TS_W'((i + 1) / 16), idle_in, (i == conn_at));
         else             step(1'b1, '0, next_in, 1'b0);
      end
      chk(errs == 0, "R4 sweep order / R3 flags held", errs, 0);
      chk(writes == DEPTH, "R4 write count", writes, DEPTH);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      frame_sync = 1'b0; ts = '0; init_n = 1'b1; conn_set = 1'b0;
      step(0, 0, 1, 0);
      chk(bus_drv_dis === 1'b0, "R1 bus flag in reset", bus_drv_dis, 0);
      chk(pcm_drv_dis === 1'b1, "R1 pcm flag in reset", pcm_drv_dis, 1);
      chk(mem_clr_we === 1'b0, "R1 no write in reset", mem_clr_we, 0);
      rst_n = 1'b1;
      step(0, 0, 1, 0);
      chk(bus_drv_dis === 1'b0 && mem_clr_we === 1'b0, "R1 idle after reset",
          bus_drv_dis, 0);

      // Vector table: one probe each, then a releasing strobe
      for (int v = 0; v < 6; v++) begin
         step(VEC[v][7], VEC[v][6:2], VEC[v][1], 1'b0);
         chk(bus_drv_dis === VEC[v][0], VEC[v][0] ? "R3 table start" : "R2 table ignore",
             bus_drv_dis, VEC[v][0]);
         step(1, 0, 1, 0);
         chk(bus_drv_dis === 1'b0, "R6 table release", bus_drv_dis, 0);
      end

      // R2: request held low with no strobe for many cycles
      begin
         int errs = 0;
         for (int i = 0; i < 20; i++) begin
            step(0, TS_W'(i % 3), 0, 0);
            if (bus_drv_dis !== 1'b0 || mem_clr_we !== 1'b0) errs++;
         end
         chk(errs == 0, "R2 low request between strobes", errs, 0);
      end

      // R3/R4/R7: one-cycle request, conn_set mid-pass, release
      step(1, 0, 0, 0);
      chk(mem_clr_we === 1'b1 && mem_clr_addr === '0, "R3 first write at addr 0",
          mem_clr_addr, 0);
      frame_pass(1'b1, FRAME, 100, 1'b1);
      chk(bus_drv_dis === 1'b0, "R6 bus released", bus_drv_dis, 0);
      chk(mem_clr_we === 1'b0, "R6 writes stopped", mem_clr_we, 0);
      chk(pcm_drv_dis === 1'b1, "R7 pcm stays disabled", pcm_drv_dis, 1);
      step(0, 3, 1, 0);
      chk(pcm_drv_dis === 1'b1, "R7 pcm still disabled", pcm_drv_dis, 1);
      step(0, 4, 1, 1);
      chk(pcm_drv_dis === 1'b0, "R7 pcm enabled by conn_set", pcm_drv_dis, 0);

      // R5: request held low across two strobes
      step(1, 0, 0, 0);
      chk(pcm_drv_dis === 1'b1, "R3 pcm disabled again", pcm_drv_dis, 1);
      frame_pass(1'b0, FRAME, -1, 1'b0);
      chk(bus_drv_dis === 1'b1 && mem_clr_we === 1'b1 && mem_clr_addr === '0,
          "R5 restart at addr 0", mem_clr_addr, 0);
      frame_pass(1'b0, FRAME, -1, 1'b1);
      chk(bus_drv_dis === 1'b0, "R6 release after second pass", bus_drv_dis, 0);

      // R4: late strobe, no writes past the last address
      step(1, 0, 0, 0);
      frame_pass(1'b1, FRAME + 80, -1, 1'b1);
      chk(bus_drv_dis === 1'b0 && mem_clr_we === 1'b0, "R8 no write when released",
          mem_clr_we, 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule